// File: doc/BRIEF.md
# SET-Command Register Updater for an I3C Target

This block sits in an I3C target behind the command decoder. The decoder tells it that a SET-type common command has started, which command it is, and which address slot a direct command targets. The block then takes the command's data bytes one at a time, each marked by a valid strobe. From the command and its bytes it updates a small set of registers, with no interrupt or other notification.

The registers are:
- a dynamic address and its valid flag for the main target and for the virtual target;
- a mask of event enables;
- the maximum write length;
- the maximum read length and the IBI payload length;
- the pending reset-action level.

Firmware only reads them, so they leave the block as plain outputs. The length values are informational only and gate nothing. A STOP or repeated START ends the command in progress. Bytes that the block has not yet committed are then dropped.

The command is given on `cmd_kind` with a fixed encoding:

| Code | Command |
|---|---|
| 1 | enable events |
| 2 | disable events |
| 3 | set max write length |
| 4 | set max read length |
| 5 | copy static address to dynamic address |
| 6 | reset dynamic addresses |
| 7 | reset action |
| 8 | set dynamic address from static |
| 9 | set new dynamic address |

Code 0 and codes above 9 are taken as no command.

Top module: `ccc_set_updater`

## Requirements
- R1: After reset both dynamic addresses are 0 and invalid, the event enables equal the low EVT_W bits of EVT_RST (all ones by default), both lengths and the IBI length are 0, `frame_err` is low, and the reset-action level reads 0x1.
- R2: For code 1, the first data byte ORs its low EVT_W bits into the event enables. For code 2, the first data byte clears the bits that are set in it. The value of `cmd_virt` (broadcast or direct form) makes no difference. The result shows one cycle after the byte.
- R3: For code 3, the first byte is the high byte of the max write length. The second byte is the low byte. The whole value commits in the cycle after the second byte, and a single byte changes nothing.
- R4: For code 4, the max read length (first byte high, second byte low) commits in the cycle after the second byte. The third byte, the IBI length, commits in the cycle after itself. Between the two commits the new read length is seen together with the old IBI length.
- R5: Code 7 stores `cmd_defbyte` as the reset-action level when it is 0x0, 0x1 or 0x2. Any other defining byte leaves the level unchanged.
- R6: Code 6 clears the address and the valid flag of both targets in the cycle after the start.
- R7: Code 5 copies each static address into the dynamic address and sets the valid flag, for each target whose enable input is high at the start.
- R8: For code 8, bits [7:1] of the first byte are the address, for the virtual target when `cmd_virt` is 1 and the main target otherwise. If bit 0 is 0, the address and the valid flag commit in the next cycle. If bit 0 is 1, `frame_err` is high for exactly that next cycle and nothing is committed.
- R9: Code 9 follows R8, but commits only when the selected target already holds a valid address. A set bit 0 still raises `frame_err`.
- R10: A `bus_stop` ends the command. A byte strobed with `bus_stop`, a byte after the stop, and bytes beyond a command's last field change nothing. Fields committed before the stop are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a new command starts |
| cmd_kind | input | 4 | Command code, valid with `cmd_start` |
| cmd_virt | input | 1 | Direct command aimed at the virtual target |
| cmd_defbyte | input | 8 | Defining byte, valid with `cmd_start` |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| bus_stop | input | 1 | STOP or repeated START seen |
| static_addr_main | input | 7 | Static address of the main target |
| static_addr_virt | input | 7 | Static address of the virtual target |
| aasa_en_main | input | 1 | Main target takes part in code 5 |
| aasa_en_virt | input | 1 | Virtual target takes part in code 5 |
| main_da | output | 7 | Main dynamic address |
| main_da_valid | output | 1 | Main address valid |
| virt_da | output | 7 | Virtual dynamic address |
| virt_da_valid | output | 1 | Virtual address valid |
| evt_en | output | EVT_W | Event enable mask |
| max_wr_len | output | 8*LEN_BYTES | Max write length |
| max_rd_len | output | 8*LEN_BYTES | Max read length |
| ibi_len | output | 8 | IBI payload length |
| rst_action | output | 8 | Pending reset-action level |
| frame_err | output | 1 | One-cycle pulse: address padding bit set |

## Verification
Every register output changes one clock after the edge that samples the start pulse or data byte causing it. `frame_err` is high only in the cycle that follows the offending byte. The bench drives each start, byte and stop on a falling edge and releases it on the next falling edge. It compares all outputs at that second falling edge, after exactly one rising edge. The expected value therefore includes every commit due so far, including the intermediate state of the split read-length commit.

// File: rtl/ccc_set_pkg.sv
package ccc_set_pkg;
   typedef enum logic [3:0] {
      CK_NONE     = 4'd0,
      CK_ENEC     = 4'd1,
      CK_DISEC    = 4'd2,
      CK_SETMWL   = 4'd3,
      CK_SETMRL   = 4'd4,
      CK_SETAASA  = 4'd5,
      CK_RSTDAA   = 4'd6,
      CK_RSTACT   = 4'd7,
      CK_SETDASA  = 4'd8,
      CK_SETNEWDA = 4'd9
   } ccc_kind_e;

   localparam int unsigned TGT_MAIN = 0;
   localparam int unsigned TGT_VIRT = 1;
   localparam int unsigned NUM_TGT  = 2;
   localparam int unsigned DA_W     = 7;
endpackage

// File: rtl/ccc_cmd_tracker.sv
module ccc_cmd_tracker
   import ccc_set_pkg::*;
#(
   parameter int unsigned IDX_W = 2,
   parameter int unsigned IDX_MAX = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [3:0]       cmd_kind,
   input  logic             cmd_virt,
   input  logic             bus_stop,
   input  logic             byte_valid,
   output ccc_kind_e        act_kind,
   output logic             act_virt,
   output logic [IDX_W-1:0] byte_idx,
   output logic             byte_take
);
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(IDX_MAX);

   logic known;
   assign known = (cmd_kind != 4'd0) && (cmd_kind <= 4'(CK_SETNEWDA));

   assign byte_take = byte_valid && !bus_stop && !cmd_start && (act_kind != CK_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_kind <= CK_NONE;
         act_virt <= 1'b0;
         byte_idx <= '0;
      end else if (cmd_start) begin
         act_kind <= known ? ccc_kind_e'(cmd_kind) : CK_NONE;
         act_virt <= cmd_virt;
         byte_idx <= '0;
      end else if (bus_stop) begin
         act_kind <= CK_NONE;
         byte_idx <= '0;
      end else if (byte_take && (byte_idx != IDX_TOP)) begin
         byte_idx <= byte_idx + 1'b1;
      end
   end
endmodule

// File: rtl/ccc_dyn_addr_slot.sv
module ccc_dyn_addr_slot #(
   parameter int unsigned ADDR_W = 7
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              copy_static,
   input  logic [ADDR_W-1:0] static_addr,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] da,
   output logic              da_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         da       <= '0;
         da_valid <= 1'b0;
      end else if (clr) begin
         da       <= '0;
         da_valid <= 1'b0;
      end else if (copy_static) begin
         da       <= static_addr;
         da_valid <= 1'b1;
      end else if (wr) begin
         da       <= wr_addr;
         da_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/ccc_len_regs.sv
module ccc_len_regs #(
   parameter int unsigned LEN_BYTES = 2,
   parameter int unsigned IDX_W = 2,
   localparam int unsigned LEN_W = 8 * LEN_BYTES
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mwl_take,
   input  logic             mrl_take,
   input  logic [IDX_W-1:0] idx,
   input  logic [7:0]       data,
   output logic [LEN_W-1:0] mwl,
   output logic [LEN_W-1:0] mrl,
   output logic [7:0]       ibi
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN_BYTES - 1);
   localparam logic [IDX_W-1:0] IBI_IDX  = IDX_W'(LEN_BYTES);

   logic [LEN_W-1:0] full;

   generate
      if (LEN_BYTES > 1) begin : g_hold
         localparam int unsigned HOLD_W = LEN_W - 8;
         logic [HOLD_W-1:0] hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               hold <= '0;
            else if ((mwl_take || mrl_take) && (idx < LAST_IDX))
               hold <= HOLD_W'({hold, data});
         end
         assign full = {hold, data};
      end else begin : g_direct
         assign full = data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mwl <= '0;
         mrl <= '0;
         ibi <= '0;
      end else begin
         if (mwl_take && (idx == LAST_IDX))
            mwl <= full;
         if (mrl_take && (idx == LAST_IDX))
            mrl <= full;
         else if (mrl_take && (idx == IBI_IDX))
            ibi <= data;
      end
   end
endmodule

// File: rtl/ccc_set_updater.sv
module ccc_set_updater
   import ccc_set_pkg::*;
#(
   parameter int unsigned EVT_W       = 4,
   parameter logic [7:0]  EVT_RST     = 8'hFF,
   parameter int unsigned LEN_BYTES   = 2,
   parameter logic [7:0]  RSTACT_DFLT = 8'h01,
   parameter logic [7:0]  RSTACT_MAX  = 8'h02,
   localparam int unsigned LEN_W      = 8 * LEN_BYTES
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [3:0]       cmd_kind,
   input  logic             cmd_virt,
   input  logic [7:0]       cmd_defbyte,
   input  logic             byte_valid,
   input  logic [7:0]       byte_data,
   input  logic             bus_stop,
   input  logic [6:0]       static_addr_main,
   input  logic [6:0]       static_addr_virt,
   input  logic             aasa_en_main,
   input  logic             aasa_en_virt,
   output logic [6:0]       main_da,
   output logic             main_da_valid,
   output logic [6:0]       virt_da,
   output logic             virt_da_valid,
   output logic [EVT_W-1:0] evt_en,
   output logic [LEN_W-1:0] max_wr_len,
   output logic [LEN_W-1:0] max_rd_len,
   output logic [7:0]       ibi_len,
   output logic [7:0]       rst_action,
   output logic             frame_err
);
   localparam int unsigned IDX_MAX = LEN_BYTES + 1;
   localparam int unsigned IDX_W   = $clog2(IDX_MAX + 1);

   generate
      if (EVT_W < 1 || EVT_W > 8) begin : g_bad_evt
         $error("EVT_W must lie in 1..8");
      end
      if (LEN_BYTES < 1 || LEN_BYTES > 4) begin : g_bad_len
         $error("LEN_BYTES must lie in 1..4");
      end
      if (RSTACT_DFLT > RSTACT_MAX) begin : g_bad_ra
         $error("RSTACT_DFLT must not exceed RSTACT_MAX");
      end
   endgenerate

   ccc_kind_e        kind;
   logic             virt;
   logic [IDX_W-1:0] idx;
   logic             take;

   ccc_cmd_tracker #(.IDX_W(IDX_W), .IDX_MAX(IDX_MAX)) i_trk (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
      .cmd_virt(cmd_virt), .bus_stop(bus_stop), .byte_valid(byte_valid),
      .act_kind(kind), .act_virt(virt), .byte_idx(idx), .byte_take(take)
   );

   logic lead, da_cmd;
   assign lead   = take && (idx == '0);
   assign da_cmd = (kind == CK_SETDASA) || (kind == CK_SETNEWDA);

   logic [DA_W-1:0] st_addr [NUM_TGT];
   logic            aasa_en [NUM_TGT];
   logic [DA_W-1:0] da_q    [NUM_TGT];
   logic            vld_q   [NUM_TGT];

   assign st_addr[TGT_MAIN] = static_addr_main;
   assign st_addr[TGT_VIRT] = static_addr_virt;
   assign aasa_en[TGT_MAIN] = aasa_en_main;
   assign aasa_en[TGT_VIRT] = aasa_en_virt;

   logic clr_all;
   assign clr_all = cmd_start && (cmd_kind == 4'(CK_RSTDAA));

   for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
      localparam logic IS_VIRT = (g == TGT_VIRT);
      logic sel, wr, cp;
      assign sel = (virt == IS_VIRT);
      assign cp  = cmd_start && (cmd_kind == 4'(CK_SETAASA)) && aasa_en[g];
      assign wr  = lead && sel && !byte_data[0] &&
                   ((kind == CK_SETDASA) || ((kind == CK_SETNEWDA) && vld_q[g]));
      ccc_dyn_addr_slot #(.ADDR_W(DA_W)) i_slot (
         .clk(clk), .rst_n(rst_n), .clr(clr_all), .copy_static(cp),
         .static_addr(st_addr[g]), .wr(wr), .wr_addr(byte_data[7:1]),
         .da(da_q[g]), .da_valid(vld_q[g])
      );
   end

   assign main_da       = da_q[TGT_MAIN];
   assign main_da_valid = vld_q[TGT_MAIN];
   assign virt_da       = da_q[TGT_VIRT];
   assign virt_da_valid = vld_q[TGT_VIRT];

   ccc_len_regs #(.LEN_BYTES(LEN_BYTES), .IDX_W(IDX_W)) i_len (
      .clk(clk), .rst_n(rst_n),
      .mwl_take(take && (kind == CK_SETMWL)),
      .mrl_take(take && (kind == CK_SETMRL)),
      .idx(idx), .data(byte_data),
      .mwl(max_wr_len), .mrl(max_rd_len), .ibi(ibi_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_en     <= EVT_RST[EVT_W-1:0];
         rst_action <= RSTACT_DFLT;
         frame_err  <= 1'b0;
      end else begin
         if (lead && (kind == CK_ENEC))
            evt_en <= evt_en | byte_data[EVT_W-1:0];
         else if (lead && (kind == CK_DISEC))
            evt_en <= evt_en & ~byte_data[EVT_W-1:0];
         if (cmd_start && (cmd_kind == 4'(CK_RSTACT)) && (cmd_defbyte <= RSTACT_MAX))
            rst_action <= cmd_defbyte;
         frame_err <= lead && da_cmd && byte_data[0];
      end
   end
endmodule

// File: rtl/ccc_set_updater_chk.sv
module ccc_set_updater_chk
   import ccc_set_pkg::*;
#(
   parameter int unsigned EVT_W = 4,
   parameter int unsigned LEN_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_start,
   input logic [3:0]       cmd_kind,
   input logic             byte_valid,
   input logic [6:0]       main_da,
   input logic             main_da_valid,
   input logic [6:0]       virt_da,
   input logic             virt_da_valid,
   input logic [EVT_W-1:0] evt_en,
   input logic [LEN_W-1:0] max_wr_len,
   input logic [LEN_W-1:0] max_rd_len,
   input logic [7:0]       ibi_len,
   input logic [7:0]       rst_action,
   input logic             frame_err
);
   AST_RSTDAA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && cmd_kind == 4'(CK_RSTDAA)) |=> (!main_da_valid && !virt_da_valid)); // R6

   AST_PAD_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> ($stable(main_da) && $stable(virt_da) &&
                     $stable(main_da_valid) && $stable(virt_da_valid))); // R8

   AST_FE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> $past(byte_valid)); // R8

   AST_MRL_IBI_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(max_rd_len) |-> $stable(ibi_len)); // R4

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_start && !byte_valid) |=> ($stable(evt_en) && $stable(max_wr_len) &&
         $stable(max_rd_len) && $stable(ibi_len) && $stable(rst_action) &&
         $stable(main_da) && $stable(virt_da) &&
         $stable(main_da_valid) && $stable(virt_da_valid))); // R10

   AST_RSTACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rst_action <= 8'd2); // R5
endmodule

bind ccc_set_updater ccc_set_updater_chk #(.EVT_W(EVT_W), .LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_ccc_set_updater.sv
module test_ccc_set_updater;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cmd_start = 0, cmd_virt = 0, byte_valid = 0, bus_stop = 0;
   logic [3:0] cmd_kind = '0;
   logic [7:0] cmd_defbyte = '0, byte_data = '0;
   logic [6:0] static_addr_main = 7'h1A, static_addr_virt = 7'h55;
   logic       aasa_en_main = 0, aasa_en_virt = 0;
   logic [6:0] main_da, virt_da;
   logic       main_da_valid, virt_da_valid, frame_err;
   logic [3:0] evt_en;
   logic [15:0] max_wr_len, max_rd_len;
   logic [7:0] ibi_len, rst_action;

   int n_vec = 0, n_bad = 0;

   logic [6:0]  m_da [2];
   logic        m_v  [2];
   logic [3:0]  m_evt;
   logic [15:0] m_mwl, m_mrl;
   logic [7:0]  m_ibi, m_ra, m_hold;
   int          cur_k, cur_idx;
   bit          cur_v;

   ccc_set_updater i_ccc_set_updater (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cmp_all(string req);
      chk(req, "main_da", main_da, m_da[0]);
      chk(req, "main_valid", main_da_valid, m_v[0]);
      chk(req, "virt_da", virt_da, m_da[1]);
      chk(req, "virt_valid", virt_da_valid, m_v[1]);
      chk(req, "evt_en", evt_en, m_evt);
      chk(req, "max_wr_len", max_wr_len, m_mwl);
      chk(req, "max_rd_len", max_rd_len, m_mrl);
      chk(req, "ibi_len", ibi_len, m_ibi);
      chk(req, "rst_action", rst_action, m_ra);
   endtask

   function automatic string req_of(int k);
      case (k)
         1, 2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R7";
         6: return "R6";
         7: return "R5";
         8: return "R8";
         9: return "R9";
         default: return "R10";
      endcase
   endfunction

   // expected frame error for a byte of the current command (R8, R9)
   function automatic bit f_fe(int k, int idx, logic [7:0] d);
      return (k == 8 || k == 9) && idx == 0 && d[0];
   endfunction

   task automatic model_byte(logic [7:0] d);
      case (cur_k)
         1: if (cur_idx == 0) m_evt = m_evt | d[3:0];
         2: if (cur_idx == 0) m_evt = m_evt & ~d[3:0];
         3: if (cur_idx == 0) m_hold = d; else if (cur_idx == 1) m_mwl = {m_hold, d};
         4: if (cur_idx == 0) m_hold = d;
            else if (cur_idx == 1) m_mrl = {m_hold, d};
            else if (cur_idx == 2) m_ibi = d;
         8, 9: if (cur_idx == 0 && !d[0] && (cur_k == 8 || m_v[cur_v])) begin
                  m_da[cur_v] = d[7:1];
                  m_v[cur_v] = 1'b1;
               end
         default: ;
      endcase
      if (cur_idx < 3) cur_idx++;
   endtask

   task automatic do_start(int k, bit v, logic [7:0] def, bit en_m, bit en_v);
      @(negedge clk);
      cmd_start = 1; cmd_kind = k[3:0]; cmd_virt = v; cmd_defbyte = def;
      aasa_en_main = en_m; aasa_en_virt = en_v;
      @(negedge clk);
      cmd_start = 0;
      cur_k = (k > 9) ? 0 : k; cur_v = v; cur_idx = 0;
      if (k == 5) begin
         if (en_m) begin m_da[0] = static_addr_main; m_v[0] = 1; end
         if (en_v) begin m_da[1] = static_addr_virt; m_v[1] = 1; end
      end else if (k == 6) begin
         m_da[0] = 0; m_v[0] = 0; m_da[1] = 0; m_v[1] = 0;
      end else if (k == 7 && def <= 8'd2) begin
         m_ra = def;
      end
      cmp_all(req_of(k));
      chk(req_of(k), "frame_err", frame_err, 0);
   endtask

   task automatic do_byte(logic [7:0] d, bit stop_too = 0);
      bit efe;
      @(negedge clk);
      byte_valid = 1; byte_data = d; bus_stop = stop_too;
      @(negedge clk);
      byte_valid = 0; bus_stop = 0;
      efe = 0;
      if (stop_too) cur_k = 0;
      else if (cur_k != 0) begin
         efe = f_fe(cur_k, cur_idx, d);
         model_byte(d);
      end
      cmp_all(stop_too ? "R10" : req_of(cur_k));
      chk(stop_too ? "R10" : "R8", "frame_err", frame_err, efe);
   endtask

   task automatic do_stop();
      @(negedge clk); bus_stop = 1;
      @(negedge clk); bus_stop = 0;
      cur_k = 0;
      cmp_all("R10");
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", "main_valid", main_da_valid, 0);
      chk("R1", "virt_valid", virt_da_valid, 0);
      chk("R1", "evt_en", evt_en, 4'hF);
      chk("R1", "max_wr_len", max_wr_len, 0);
      chk("R1", "max_rd_len", max_rd_len, 0);
      chk("R1", "ibi_len", ibi_len, 0);
      chk("R1", "rst_action", rst_action, 8'h01);
      chk("R1", "frame_err", frame_err, 0);
      rst_n = 1;
      m_da[0] = 0; m_da[1] = 0; m_v[0] = 0; m_v[1] = 0;
      m_evt = 4'hF; m_mwl = 0; m_mrl = 0; m_ibi = 0; m_ra = 8'h01; m_hold = 0;
      cur_k = 0; cur_idx = 0; cur_v = 0;

      // R2: direct disable, then broadcast enable
      do_start(2, 1, 0, 0, 0); do_byte(8'h05); do_stop();
      chk("R2", "evt_en after disable", evt_en, 4'hA);
      do_start(1, 0, 0, 0, 0); do_byte(8'h01); do_byte(8'h04); do_stop();
      chk("R2", "evt_en after enable", evt_en, 4'hB);

      // R3: one cycle commit of both bytes
      do_start(3, 0, 0, 0, 0); do_byte(8'h12);
      chk("R3", "mwl after one byte", max_wr_len, 0);
      do_byte(8'h34);
      chk("R3", "mwl", max_wr_len, 16'h1234);
      do_stop();

      // R4: split commit, intermediate state visible
      do_start(4, 0, 0, 0, 0); do_byte(8'hAB); do_byte(8'hCD);
      chk("R4", "mrl mid", max_rd_len, 16'hABCD);
      chk("R4", "ibi mid", ibi_len, 8'h00);
      do_byte(8'h40);
      chk("R4", "ibi", ibi_len, 8'h40);
      do_stop();

      // R5: legal and illegal defining bytes
      do_start(7, 0, 8'h02, 0, 0); do_stop();
      chk("R5", "rst_action", rst_action, 8'h02);
      do_start(7, 0, 8'h85, 0, 0); do_stop();
      chk("R5", "rst_action kept", rst_action, 8'h02);

      // R7: copy for main only
      do_start(5, 0, 0, 1, 0); do_stop();
      chk("R7", "main_da", main_da, 7'h1A);
      chk("R7", "virt_valid", virt_da_valid, 0);

      // R8: padding error on virtual, then a good write
      do_start(8, 1, 0, 0, 0); do_byte(8'h23);
      chk("R8", "frame_err", frame_err, 1);
      chk("R8", "virt_valid", virt_da_valid, 0);
      do_stop();
      do_start(8, 1, 0, 0, 0); do_byte(8'h46); do_stop();
      chk("R8", "virt_da", virt_da, 7'h23);

      // R6
      do_start(6, 0, 0, 0, 0);
      chk("R6", "both invalid", {main_da_valid, virt_da_valid}, 2'b00);
      do_stop();

      // R9: new address needs a valid one first
      do_start(9, 0, 0, 0, 0); do_byte(8'h50); do_stop();
      chk("R9", "main_valid", main_da_valid, 0);
      do_start(8, 0, 0, 0, 0); do_byte(8'h50); do_stop();
      do_start(9, 0, 0, 0, 0); do_byte(8'h60); do_stop();
      chk("R9", "main_da", main_da, 7'h30);

      // R10: drops on stop, committed fields kept
      do_start(3, 0, 0, 0, 0); do_byte(8'h99); do_stop();
      chk("R10", "mwl kept", max_wr_len, 16'h1234);
      do_start(4, 0, 0, 0, 0); do_byte(8'h11); do_byte(8'h22); do_byte(8'h33, 1);
      chk("R10", "mrl committed", max_rd_len, 16'h1122);
      chk("R10", "ibi kept", ibi_len, 8'h40);
      do_byte(8'h77);

      // constrained random commands
      for (int n = 0; n < 400; n++) begin
         int k, nb;
         k  = $urandom_range(0, 11);
         nb = $urandom_range(0, 4);
         do_start(k, 1'($urandom), 8'($urandom_range(0, 4)), 1'($urandom), 1'($urandom));
         for (int b = 0; b < nb; b++)
            do_byte(8'($urandom), ($urandom_range(0, 9) == 0));
         do_stop();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule